// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block turns single read and write requests from a simple synchronous processor bus into the strobe sequence that an asynchronous DRAM with a shared row/column address bus expects. On each accepted request it latches the address, the direction and the write data. It drives the upper (row) half of the address and pulls RAS low. After a set RAS-to-CAS delay it switches the pins to the lower (column) half and pulls CAS low. It then holds the access for a fixed number of wait states and ends with a RAS-high precharge interval.

The number of wait states and the length of the precharge are chosen from the DRAM's full cycle time, not from its row access time. This gives every access the same length. The requester sees a one-clock ready pulse, and on a read the captured data comes with it. A request that arrives while the previous access is still precharging is held and started as soon as the precharge ends. A request that arrives earlier in an access is dropped.

Top module: `dseq_top`

## Requirements
- R1: While reset is applied, and afterwards with no request, RAS, CAS, OE and W are all high (inactive), `ready_o` is low and `dram_dq_oe_o` is low.
- R2: RAS falls with the upper `ROW_W` bits of the request address on `dram_a_o`, and these bits stay unchanged while RAS is low and CAS is high. CAS falls with the lower `COL_W` bits on `dram_a_o`, upper pins zero. CAS is never low while RAS is high.
- R3: On a read (`we_i`=0), OE goes low together with CAS. W stays high and `dram_dq_oe_o` stays low for the whole access.
- R4: On a write (`we_i`=1), W goes low together with CAS, and `dram_dq_oe_o` is high with the latched write data on `dram_dq_o`. OE stays high.
- R5: `ready_o` is a one-clock pulse. It is high in the clock that follows the rising edge `RCD_CLKS+WAIT_CLKS+1` edges after the edge that accepted the request. On a read, `rdata_o` then holds the value of `dram_dq_i` at the last wait-state edge.
- R6: CAS falls exactly `RCD_CLKS` clocks after RAS falls.
- R7: Between two accesses, RAS stays high for at least `PRE_CLKS` clocks.
- R8: A request that arrives during precharge is kept without being repeated. Its RAS fall comes exactly `PRE_CLKS` clocks after the previous access's RAS rise, and it completes like any other access.
- R9: A request that arrives while RAS is low is ignored: it produces no ready pulse and does not change memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | One-clock request pulse |
| we_i | input | 1 | 1 = write, 0 = read, sampled with `req_i` |
| addr_i | input | ROW_W+COL_W | Word address: row in upper bits, column in lower bits |
| wdata_i | input | DATA_W | Write data, sampled with `req_i` |
| ready_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Read data, valid with `ready_o` |
| dram_a_o | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_dq_o | output | DATA_W | Write data toward the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | DATA_W | Data from the DRAM |

## Verification
The bench builds the block with a 5-bit row and a 4-bit column. This unequal split exercises the zero padding of the narrower half on the shared pins. It uses a RAS-to-CAS delay of 2, 3 wait states and a 3-clock precharge. With these values every phase lasts more than one clock, so an off-by-one in any counter changes the measured latency, the RAS-to-CAS gap or the RAS-high gap. The 3-clock precharge leaves room to place one request in precharge, where it is held, and another one in the row phase, where it is dropped.

// File: rtl/dseq_pkg.sv
`timescale 1ns/1ps
package dseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_WAIT = 3'd3,
    ST_PRE  = 3'd4
  } dseq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dseq_rst_sync.sv
`timescale 1ns/1ps
module dseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/dseq_timer.sv
`timescale 1ns/1ps
module dseq_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dseq_fsm.sv
`timescale 1ns/1ps
module dseq_fsm
  import dseq_pkg::*;
#(
  parameter int unsigned RCD_CLKS  = 2,
  parameter int unsigned WAIT_CLKS = 4,
  parameter int unsigned PRE_CLKS  = 2,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             tmr_done_i,
  output dseq_state_e      state_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o
);
  localparam logic [CNT_W-1:0] RCD_V  = CNT_W'(RCD_CLKS - 1);
  localparam logic [CNT_W-1:0] WAIT_V = CNT_W'(WAIT_CLKS - 1);
  localparam logic [CNT_W-1:0] PRE_V  = CNT_W'(PRE_CLKS - 1);

  dseq_state_e state_q, state_d;
  logic        pend_q, pend_d;

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d    = ST_ROW;
          tmr_load_o = 1'b1;
          tmr_val_o  = RCD_V;
          accept_o   = 1'b1;
        end
      end
      ST_ROW: begin
        if (tmr_done_i) begin
          state_d    = ST_COL;
          tmr_load_o = 1'b1;
        end
      end
      ST_COL: begin
        state_d    = ST_WAIT;
        tmr_load_o = 1'b1;
        tmr_val_o  = WAIT_V;
      end
      ST_WAIT: begin
        if (tmr_done_i) begin
          state_d    = ST_PRE;
          tmr_load_o = 1'b1;
          tmr_val_o  = PRE_V;
          capture_o  = 1'b1;
        end
      end
      ST_PRE: begin
        if (req_i && !pend_q) begin
          accept_o = 1'b1;
          pend_d   = 1'b1;
        end
        if (tmr_done_i) begin
          if (pend_d) begin
            state_d    = ST_ROW;
            tmr_load_o = 1'b1;
            tmr_val_o  = RCD_V;
            pend_d     = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o = state_q;

  // RAS-high run length, kept for the precharge check
  logic             ras_hi;
  logic [CNT_W-1:0] hi_cnt_q;
  assign ras_hi = (state_q == ST_IDLE) || (state_q == ST_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            hi_cnt_q <= CNT_W'(PRE_CLKS);
    else if (!ras_hi)                      hi_cnt_q <= '0;
    else if (hi_cnt_q != CNT_W'(PRE_CLKS)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  AST_PRE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROW && $past(ras_hi)) |-> (hi_cnt_q >= CNT_W'(PRE_CLKS))); // R7

  AST_PEND_IN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (state_q == ST_PRE)); // R8
endmodule

// File: rtl/dseq_datapath.sv
`timescale 1ns/1ps
module dseq_datapath
  import dseq_pkg::*;
#(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MA_W   = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept_i,
  input  logic                   capture_i,
  input  dseq_state_e            state_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic                   we_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [DATA_W-1:0]      dq_i,
  output logic [MA_W-1:0]        addr_o,
  output logic                   we_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic                   ready_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int unsigned AW = ROW_W + COL_W;

  logic [AW-1:0]     addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= capture_i;
  end

  logic [ROW_W-1:0] row_bits;
  logic [COL_W-1:0] col_bits;
  logic [MA_W-1:0]  row_pad, col_pad;
  assign row_bits = addr_q[AW-1:COL_W];
  assign col_bits = addr_q[COL_W-1:0];

  if (MA_W > ROW_W) begin : g_row_pad
    assign row_pad = {{(MA_W-ROW_W){1'b0}}, row_bits};
  end else begin : g_row_full
    assign row_pad = row_bits;
  end

  if (MA_W > COL_W) begin : g_col_pad
    assign col_pad = {{(MA_W-COL_W){1'b0}}, col_bits};
  end else begin : g_col_full
    assign col_pad = col_bits;
  end

  assign addr_o  = (state_i == ST_COL || state_i == ST_WAIT) ? col_pad : row_pad;
  assign we_o    = we_q;
  assign wdata_o = wdata_q;
  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

  AST_ROW_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_ROW && $past(state_i) == ST_ROW) |-> $stable(addr_o)); // R2

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q); // R5
endmodule

// File: rtl/dseq_top.sv
`timescale 1ns/1ps
module dseq_top
  import dseq_pkg::*;
#(
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RCD_CLKS  = 2,
  parameter int unsigned WAIT_CLKS = 4,
  parameter int unsigned PRE_CLKS  = 2,
  localparam int unsigned MA_W     = max2(ROW_W, COL_W),
  localparam int unsigned AW       = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MA_W-1:0]   dram_a_o,
  output logic              dram_ras_n_o,
  output logic              dram_cas_n_o,
  output logic              dram_oe_n_o,
  output logic              dram_we_n_o,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam int unsigned MAX_CLKS = max2(max2(RCD_CLKS, WAIT_CLKS), PRE_CLKS);
  localparam int unsigned CNT_W    = $clog2(MAX_CLKS + 1);

  logic             rst_n_s;
  logic             tmr_load, tmr_done, accept, capture, we_q;
  logic [CNT_W-1:0] tmr_val;
  dseq_state_e      state;

  dseq_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  dseq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  dseq_fsm #(
    .RCD_CLKS  (RCD_CLKS),
    .WAIT_CLKS (WAIT_CLKS),
    .PRE_CLKS  (PRE_CLKS),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_i      (req_i),
    .tmr_done_i (tmr_done),
    .state_o    (state),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .accept_o   (accept),
    .capture_o  (capture)
  );

  dseq_datapath #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .MA_W   (MA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept_i  (accept),
    .capture_i (capture),
    .state_i   (state),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .dq_i      (dram_dq_i),
    .addr_o    (dram_a_o),
    .we_o      (we_q),
    .wdata_o   (dram_dq_o),
    .ready_o   (ready_o),
    .rdata_o   (rdata_o)
  );

  logic row_open, col_open;
  assign row_open = (state == ST_ROW) || (state == ST_COL) || (state == ST_WAIT);
  assign col_open = (state == ST_COL) || (state == ST_WAIT);

  assign dram_ras_n_o = !row_open;
  assign dram_cas_n_o = !col_open;
  assign dram_oe_n_o  = !(col_open && !we_q);
  assign dram_we_n_o  = !(col_open && we_q);
  assign dram_dq_oe_o = col_open && we_q;

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dram_cas_n_o |-> !dram_ras_n_o); // R2

  AST_OE_W_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!dram_oe_n_o && !dram_we_n_o)); // R3

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dram_we_n_o |-> (dram_dq_oe_o && dram_oe_n_o)); // R4

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n_s |-> (dram_ras_n_o && dram_cas_n_o && !ready_o)); // R1
endmodule

// File: tb/dseq_top_tb_top.sv
`timescale 1ns/1ps
module dseq_top_tb_top;
  localparam int ROW_W = 5;
  localparam int COL_W = 4;
  localparam int DW    = 8;
  localparam int RCD   = 2;
  localparam int WT    = 3;
  localparam int PRE   = 3;
  localparam int AW    = ROW_W + COL_W;
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req, we, ready, ras_n, cas_n, oe_n, we_n, dq_oe;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   wdata, rdata, dq_o, dq_i;
  logic [MA_W-1:0] dram_a;

  dseq_top #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
             .RCD_CLKS(RCD), .WAIT_CLKS(WT), .PRE_CLKS(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata), .dram_a_o(dram_a), .dram_ras_n_o(ras_n),
    .dram_cas_n_o(cas_n), .dram_oe_n_o(oe_n), .dram_we_n_o(we_n), .dram_dq_o(dq_o),
    .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i));

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // behavioural DRAM with bookkeeping of strobe timing
  logic [DW-1:0]    mem    [0:(1<<AW)-1];
  logic [DW-1:0]    shadow [0:(1<<AW)-1];
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;
  int col_hi = 0, hi_gap = 100, last_hi = 0, rc_gap = 0, last_rc = 0;
  bit prev_ras = 1, prev_cas = 1, saw_oe = 0, saw_w = 0, saw_dqoe = 0;

  assign dq_i = (!oe_n && !cas_n) ? mem[{m_row, m_col}] : '0;

  always @(negedge clk) begin
    if (prev_ras && !ras_n) begin
      m_row = dram_a[ROW_W-1:0];
      last_hi = hi_gap; hi_gap = 0; rc_gap = 0;
      saw_oe = 0; saw_w = 0; saw_dqoe = 0;
    end
    if (prev_cas && !cas_n) begin
      m_col = dram_a[COL_W-1:0];
      col_hi = int'(dram_a >> COL_W);
      last_rc = rc_gap;
    end
    if (ras_n) hi_gap++;
    if (!ras_n && cas_n) rc_gap++;
    if (!cas_n) begin
      if (!oe_n) saw_oe = 1;
      if (!we_n) saw_w = 1;
      if (dq_oe) saw_dqoe = 1;
      if (!we_n) mem[{m_row, m_col}] = dq_o;
    end
    prev_ras = ras_n; prev_cas = cas_n;
  end

  typedef struct {
    bit we; logic [AW-1:0] addr; logic [DW-1:0] data; int acc; bit chk_lat; bit gap_exact;
  } item_t;
  item_t q[$];

  // monitor: pops expected item per ready pulse
  bit prev_ready = 0;
  always @(negedge clk) begin
    if (rst_n && prev_ready && ready) chk(0, "R5", "ready wider than one clock", 1, 0);
    if (rst_n && ready) begin
      if (q.size() == 0) chk(0, "R9", "ready with no accepted request", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        if (it.chk_lat) chk(cyc == it.acc + RCD + WT + 1, "R5", "ready latency", cyc - it.acc, RCD + WT + 1);
        if (!it.we) chk(rdata == it.data, "R5", "read data", rdata, it.data);
        chk(m_row == it.addr[AW-1:COL_W], "R2", "row on pins at RAS fall", m_row, it.addr[AW-1:COL_W]);
        chk(m_col == it.addr[COL_W-1:0], "R2", "column on pins at CAS fall", m_col, it.addr[COL_W-1:0]);
        chk(col_hi == 0, "R2", "upper pins zero in column phase", col_hi, 0);
        chk(last_rc == RCD, "R6", "RAS-to-CAS clocks", last_rc, RCD);
        if (it.we) begin
          chk(saw_w && !saw_oe && saw_dqoe, "R4", "write strobes W/OE/dq_oe", {saw_w, saw_oe, saw_dqoe}, 3'b101);
        end else begin
          chk(saw_oe && !saw_w && !saw_dqoe, "R3", "read strobes W/OE/dq_oe", {saw_w, saw_oe, saw_dqoe}, 3'b010);
        end
        if (it.gap_exact) chk(last_hi == PRE, "R8", "RAS-high gap for held request", last_hi, PRE);
        else chk(last_hi >= PRE, "R7", "RAS-high gap", last_hi, PRE);
      end
    end
    prev_ready = ready;
  end

  // driver: called at a falling edge
  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit lat, input bit gexact, input bit wait_rdy);
    item_t it;
    it.we = w; it.addr = a; it.data = w ? d : shadow[a];
    it.acc = cyc + 1; it.chk_lat = lat; it.gap_exact = gexact;
    if (w) shadow[a] = d;
    q.push_back(it);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    if (wait_rdy) while (!ready) @(negedge clk);
  endtask

  task automatic settle();
    repeat (PRE + 2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin mem[i] = '0; shadow[i] = '0; end
    rst_n = 0; req = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && oe_n && we_n, "R1", "strobes in reset", {ras_n, cas_n, oe_n, we_n}, 4'hf);
    chk(!ready && !dq_oe, "R1", "ready/dq_oe in reset", {ready, dq_oe}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && !ready, "R1", "idle with no request", {ras_n, cas_n, ready}, 3'b110);

    // writes and reads across patterns
    access(1, 9'h1A5, 8'h3C, 1, 0, 1); settle();
    access(1, 9'h0F0, 8'hC3, 1, 0, 1); settle();
    access(1, 9'h10F, 8'hFF, 1, 0, 1); settle();
    access(0, 9'h1A5, 8'h00, 1, 0, 1); settle();
    access(0, 9'h0F0, 8'h00, 1, 0, 1); settle();
    access(0, 9'h10F, 8'h00, 1, 0, 1); settle();
    access(0, 9'h000, 8'h00, 1, 0, 1); settle();
    access(1, 9'h1FF, 8'h81, 1, 0, 1); settle();
    access(0, 9'h1FF, 8'h00, 1, 0, 1); settle();

    // R8: request placed in precharge is held
    access(1, 9'h055, 8'h5A, 1, 0, 1);
    access(0, 9'h055, 8'h00, 0, 1, 1);
    access(1, 9'h0AA, 8'hA5, 0, 1, 1);
    settle();
    access(0, 9'h0AA, 8'h00, 1, 0, 1); settle();

    // R9: request during an open row is dropped
    access(1, 9'h123, 8'h77, 1, 0, 0);
    req = 1; we = 1; addr = 9'h0C6; wdata = 8'hEE;
    @(negedge clk);
    req = 0;
    while (!ready) @(negedge clk);
    repeat (PRE + 6) @(negedge clk);
    chk(q.size() == 0 && ras_n, "R9", "no second access started", q.size(), 0);
    access(0, 9'h0C6, 8'h00, 1, 0, 1); settle();
    access(0, 9'h123, 8'h00, 1, 0, 1); settle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule